// File: doc/BRIEF.md
# Directory-less Coherence Cache Site Engine

This block is the controller for one cache site in a coherence scheme that has no directory. Memory keeps no record of which sites hold which lines. It serves only as the meeting point where written-back data becomes visible to other sites. A processor issues four kinds of instruction:

- a local load;
- a local store;
- a commit, which pushes dirty data out to memory;
- a reconcile, which discards a clean copy so that the next load fetches from memory again.

The engine keeps a small fully associative array of cells. Each cell holds an address, a data word and a state. The stable states are Clean and Dirty. The transient states are FetchWait, entered after a fetch request is sent, and FlushWait, entered after a writeback is sent. An address that matches no cell counts as Invalid.

On the memory side the engine sends fetch requests (CacheReq) and writebacks (Wb) through one outgoing port. It receives data replies (Cache) and writeback acknowledgements (WbAck) on an incoming port. The outgoing port is a single registered slot, so messages leave in the order they were issued.

Processor requests, processor responses and outgoing messages use valid/ready handshakes:

- `req_ready` is a function of the request fields and the engine state. It never depends on `req_valid`.
- A response or an outgoing message is held unchanged until its ready is seen high at a clock edge.
- Only one response may be outstanding. No request is accepted while `rsp_valid` is high.
- The incoming message port is always ready. A message presented there takes priority over the processor for that cycle.

Top module: `ccs_engine`

## Requirements
- R1: After reset every cell is Invalid and `rsp_valid` and `mo_valid` are low. The first load to any address misses and sends a CacheReq.
- R2: A load (op code 0) to a Clean or Dirty cell completes with `rsp_is_load`=1, the cell's data and the request tag. It sends no message and leaves the state unchanged.
- R3: A store (op code 1) to a Clean or Dirty cell overwrites the data and makes the cell Dirty. It answers with an Ack (`rsp_is_load`=0) carrying the request tag.
- R4: A load or store to an Invalid address claims a cell in FetchWait and sends CacheReq (kind 0) with that address. It is accepted only after a Cache reply (kind 1) has made the cell Clean with the received data.
- R5: A commit (op code 2) to a Clean or Invalid address answers Ack and sends no message.
- R6: A commit to a Dirty cell sends Wb (kind 2) with the address and data and moves the cell to FlushWait. The Ack is given only after WbAck (kind 3) has made the cell Clean.
- R7: A reconcile (op code 3) to a Dirty or Invalid address answers Ack, sends no message and keeps the dirty data.
- R8: A reconcile to a Clean cell answers Ack and drops the cell. A later load to that address sends CacheReq and returns the value memory holds.
- R9: A request to a cell in FetchWait or FlushWait keeps `req_ready` low until the cell is stable. `req_ready` is also low in any cycle where `mi_valid` is high.
- R10: When a miss finds no Invalid cell, the lowest-index Clean cell is reused without any message. Dirty cells are never dropped.
- R11: When a miss finds every cell Dirty, the lowest-index Dirty cell is written back first. After its WbAck that cell is reused, and the CacheReq follows the Wb.
- R12: While `mo_valid` is high and `mo_ready` low, the outgoing kind, address and data stay unchanged. Messages leave in issue order.
- R13: While `rsp_valid` is high and `rsp_ready` low, the response stays unchanged and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | processor request valid |
| req_ready | output | 1 | request accepted at this edge when valid is also high |
| req_op | input | 2 | 0 load, 1 store, 2 commit, 3 reconcile |
| req_tag | input | TAG_W | tag echoed in the response |
| req_addr | input | ADDR_W | request address |
| req_data | input | DATA_W | store data |
| rsp_valid | output | 1 | response valid |
| rsp_ready | input | 1 | processor takes the response |
| rsp_tag | output | TAG_W | tag of the completed request |
| rsp_is_load | output | 1 | 1 for a load value, 0 for an Ack |
| rsp_data | output | DATA_W | load value (zero on Ack) |
| mo_valid | output | 1 | outgoing message valid |
| mo_ready | input | 1 | memory side takes the message |
| mo_kind | output | 2 | 0 CacheReq, 2 Wb |
| mo_addr | output | ADDR_W | message address |
| mo_data | output | DATA_W | writeback data |
| mi_valid | input | 1 | incoming message valid |
| mi_ready | output | 1 | always high |
| mi_kind | input | 2 | 1 Cache, 3 WbAck |
| mi_addr | input | ADDR_W | message address |
| mi_data | input | DATA_W | fetched data |

## Verification
The bench uses the default parameters: four cells, 8-bit addresses, 16-bit data and 4-bit tags. With only four cells, a handful of misses fills the array. That makes Clean-cell reuse reachable in a few requests, and so is the all-Dirty case where a writeback must finish before a fetch can start. A behavioural memory answers each message one cycle after taking it. The bench can hold `mo_ready` or `rsp_ready` low, which freezes the transient states and the pending response long enough to observe the stalls.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_COMMIT = 2'd2, OP_RECON = 2'd3} op_e;
  typedef enum logic [1:0] {MSG_CREQ = 2'd0, MSG_CACHE = 2'd1, MSG_WB = 2'd2, MSG_WBACK = 2'd3} msg_e;
  typedef enum logic [2:0] {ST_INV = 3'd0, ST_CLEAN = 3'd1, ST_DIRTY = 3'd2,
                            ST_FETCHW = 3'd3, ST_FLUSHW = 3'd4} cst_e;
endpackage

// File: rtl/ccs_lookup.sv
`timescale 1ns/1ps
module ccs_lookup import ccs_pkg::*; #(
  parameter int CELLS  = 4,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(CELLS)
) (
  input  logic [CELLS-1:0][2:0]        st,
  input  logic [CELLS-1:0][ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0]            key,
  output logic                         hit,
  output logic [IDX_W-1:0]             idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < CELLS; i++) begin
      if (st[i] != ST_INV && addr[i] == key) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ccs_victim.sv
`timescale 1ns/1ps
module ccs_victim import ccs_pkg::*; #(
  parameter int CELLS = 4,
  localparam int IDX_W = $clog2(CELLS)
) (
  input  logic [CELLS-1:0][2:0] st,
  output logic                  has_free,
  output logic [IDX_W-1:0]      free_idx,
  output logic                  has_clean,
  output logic [IDX_W-1:0]      clean_idx,
  output logic                  has_dirty,
  output logic [IDX_W-1:0]      dirty_idx
);
  logic [CELLS-1:0] is_free, is_clean, is_dirty;

  for (genvar g = 0; g < CELLS; g++) begin : g_cls
    assign is_free[g]  = (st[g] == ST_INV);
    assign is_clean[g] = (st[g] == ST_CLEAN);
    assign is_dirty[g] = (st[g] == ST_DIRTY);
  end

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    free_idx = '0; clean_idx = '0; dirty_idx = '0;
    for (int i = CELLS - 1; i >= 0; i--) begin
      if (is_free[i])  free_idx  = IDX_W'(i);
      if (is_clean[i]) clean_idx = IDX_W'(i);
      if (is_dirty[i]) dirty_idx = IDX_W'(i);
    end
  end

  assign has_free  = |is_free;
  assign has_clean = |is_clean;
  assign has_dirty = |is_dirty;
endmodule

// File: rtl/ccs_msg_slot.sv
`timescale 1ns/1ps
module ccs_msg_slot #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (issue) begin
      out_valid <= 1'b1;
      out_kind  <= kind;
      out_addr  <= addr;
      out_data  <= data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign busy = out_valid;
endmodule

// File: rtl/ccs_engine.sv
`timescale 1ns/1ps
module ccs_engine import ccs_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int CELLS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_is_load,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mo_valid,
  input  logic              mo_ready,
  output logic [1:0]        mo_kind,
  output logic [ADDR_W-1:0] mo_addr,
  output logic [DATA_W-1:0] mo_data,
  input  logic              mi_valid,
  output logic              mi_ready,
  input  logic [1:0]        mi_kind,
  input  logic [ADDR_W-1:0] mi_addr,
  input  logic [DATA_W-1:0] mi_data
);
  localparam int IDX_W = $clog2(CELLS);

  logic [CELLS-1:0][2:0]        st_q;
  logic [CELLS-1:0][ADDR_W-1:0] addr_q;
  logic [CELLS-1:0][DATA_W-1:0] data_q;

  logic             r_hit, m_hit;
  logic [IDX_W-1:0] r_idx, m_idx;
  logic             has_free, has_clean, has_dirty;
  logic [IDX_W-1:0] free_idx, clean_idx, dirty_idx;
  logic             mo_busy;

  ccs_lookup #(.CELLS(CELLS), .ADDR_W(ADDR_W)) u_req_lu (
    .st(st_q), .addr(addr_q), .key(req_addr), .hit(r_hit), .idx(r_idx));
  ccs_lookup #(.CELLS(CELLS), .ADDR_W(ADDR_W)) u_mi_lu (
    .st(st_q), .addr(addr_q), .key(mi_addr), .hit(m_hit), .idx(m_idx));
  ccs_victim #(.CELLS(CELLS)) u_victim (
    .st(st_q), .has_free(has_free), .free_idx(free_idx), .has_clean(has_clean),
    .clean_idx(clean_idx), .has_dirty(has_dirty), .dirty_idx(dirty_idx));

  logic [2:0]        r_st, m_st;
  logic              can_done, on_acc;
  logic              iss;
  logic [1:0]        iss_kind;
  logic [ADDR_W-1:0] iss_addr;
  logic [DATA_W-1:0] iss_data;
  logic              upd, upd_addr_en, upd_data_en;
  logic [IDX_W-1:0]  upd_idx;
  logic [2:0]        upd_st;
  logic [DATA_W-1:0] upd_data;
  logic              upd_fire, iss_fire, accept;

  assign r_st = st_q[r_idx];
  assign m_st = st_q[m_idx];

  always_comb begin
    can_done = 1'b0; on_acc = 1'b0;
    iss = 1'b0; iss_kind = MSG_CREQ; iss_addr = req_addr; iss_data = '0;
    upd = 1'b0; upd_idx = r_idx; upd_st = ST_INV;
    upd_addr_en = 1'b0; upd_data_en = 1'b0; upd_data = req_data;
    if (mi_valid) begin
      // replies have priority; stray replies are dropped
      if (m_hit && ((mi_kind == MSG_CACHE && m_st == ST_FETCHW) ||
                    (mi_kind == MSG_WBACK && m_st == ST_FLUSHW))) begin
        upd = 1'b1; upd_idx = m_idx; upd_st = ST_CLEAN;
        upd_data_en = (mi_kind == MSG_CACHE); upd_data = mi_data;
      end
    end else begin
      case (req_op)
        OP_LOAD, OP_STORE: begin
          if (r_hit) begin
            if (r_st == ST_CLEAN || r_st == ST_DIRTY) begin
              can_done = 1'b1;
              if (req_op == OP_STORE) begin
                on_acc = 1'b1; upd = 1'b1; upd_st = ST_DIRTY; upd_data_en = 1'b1;
              end
            end
          end else if (!mo_busy) begin
            if (has_free || has_clean) begin
              upd = 1'b1; upd_idx = has_free ? free_idx : clean_idx;
              upd_st = ST_FETCHW; upd_addr_en = 1'b1;
              iss = 1'b1; iss_kind = MSG_CREQ;
            end else if (has_dirty) begin
              upd = 1'b1; upd_idx = dirty_idx; upd_st = ST_FLUSHW;
              iss = 1'b1; iss_kind = MSG_WB;
              iss_addr = addr_q[dirty_idx]; iss_data = data_q[dirty_idx];
            end
          end
        end
        OP_COMMIT: begin
          if (!r_hit || r_st == ST_CLEAN) begin
            can_done = 1'b1;
          end else if (r_st == ST_DIRTY && !mo_busy) begin
            upd = 1'b1; upd_st = ST_FLUSHW;
            iss = 1'b1; iss_kind = MSG_WB; iss_data = data_q[r_idx];
          end
        end
        default: begin
          if (!r_hit || r_st == ST_DIRTY) begin
            can_done = 1'b1;
          end else if (r_st == ST_CLEAN) begin
            can_done = 1'b1; on_acc = 1'b1; upd = 1'b1; upd_st = ST_INV;
          end
        end
      endcase
    end
  end

  assign req_ready = can_done && !rsp_valid;
  assign accept    = req_ready && req_valid;
  assign upd_fire  = mi_valid ? upd : (upd && req_valid && (!on_acc || !rsp_valid));
  assign iss_fire  = iss && req_valid && !mi_valid;
  assign mi_ready  = 1'b1;

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= ST_INV;
        addr_q[g] <= '0;
        data_q[g] <= '0;
      end else if (upd_fire && upd_idx == IDX_W'(g)) begin
        st_q[g] <= upd_st;
        if (upd_addr_en) addr_q[g] <= req_addr;
        if (upd_data_en) data_q[g] <= upd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_tag <= '0; rsp_is_load <= 1'b0; rsp_data <= '0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_tag     <= req_tag;
      rsp_is_load <= (req_op == OP_LOAD);
      rsp_data    <= (req_op == OP_LOAD) ? data_q[r_idx] : '0;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  ccs_msg_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mo (
    .clk(clk), .rst_n(rst_n), .issue(iss_fire), .kind(iss_kind), .addr(iss_addr),
    .data(iss_data), .busy(mo_busy), .out_valid(mo_valid), .out_ready(mo_ready),
    .out_kind(mo_kind), .out_addr(mo_addr), .out_data(mo_data));
endmodule

// File: rtl/ccs_engine_chk.sv
`timescale 1ns/1ps
module ccs_engine_chk import ccs_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [TAG_W-1:0]  req_tag,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic              rsp_is_load,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mo_valid,
  input logic              mo_ready,
  input logic [1:0]        mo_kind,
  input logic [ADDR_W-1:0] mo_addr,
  input logic [DATA_W-1:0] mo_data,
  input logic              mi_valid
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && !mo_valid));

  a_r2_load_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OP_LOAD) |=>
      (rsp_valid && rsp_is_load && rsp_tag == $past(req_tag)));

  a_r3_store_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OP_STORE) |=>
      (rsp_valid && !rsp_is_load && rsp_tag == $past(req_tag)));

  a_r9_reply_priority: assert property (@(posedge clk) disable iff (!rst_n)
    mi_valid |-> !req_ready);

  a_r12_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mo_valid && !mo_ready) |=>
      (mo_valid && $stable(mo_kind) && $stable(mo_addr) && $stable(mo_data)));

  a_r13_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_tag) && $stable(rsp_is_load) && $stable(rsp_data)));

  a_r13_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind ccs_engine ccs_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_tag(rsp_tag), .rsp_is_load(rsp_is_load), .rsp_data(rsp_data),
  .mo_valid(mo_valid), .mo_ready(mo_ready), .mo_kind(mo_kind), .mo_addr(mo_addr),
  .mo_data(mo_data), .mi_valid(mi_valid));

// File: tb/tb_ccs_engine.sv
`timescale 1ns/1ps
module tb_ccs_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [3:0] req_tag = '0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_is_load;
  logic [3:0] rsp_tag;
  logic [15:0] rsp_data;
  logic mo_valid, mo_ready = 1'b1;
  logic [1:0] mo_kind;
  logic [7:0] mo_addr;
  logic [15:0] mo_data;
  logic mi_valid = 1'b0, mi_ready;
  logic [1:0] mi_kind = '0;
  logic [7:0] mi_addr = '0;
  logic [15:0] mi_data = '0;

  ccs_engine dut (.*);

  always #2 clk = ~clk;

  int n_vec = 0, n_bad = 0, n_creq = 0, n_wb = 0;
  logic [1:0] last_kind = '0, prev_kind = '0;
  logic [15:0] bmem [256];
  logic [3:0] tag_ctr = '0;
  logic took;
  logic [1:0] tk;
  logic [7:0] ta;
  logic [15:0] td;

  // behavioural memory: answers each taken message one cycle later
  always begin
    @(posedge clk);
    took = mo_valid && mo_ready; tk = mo_kind; ta = mo_addr; td = mo_data;
    #1;
    mi_valid = 1'b0;
    if (took) begin
      prev_kind = last_kind; last_kind = tk;
      mi_valid = 1'b1; mi_addr = ta;
      if (tk == 2'd0) begin n_creq++; mi_kind = 2'd1; mi_data = bmem[ta]; end
      else begin n_wb++; bmem[ta] = td; mi_kind = 2'd3; mi_data = '0; end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wait_ready(input string r);
    int n = 0;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      n++;
      if (n > 2000) begin chk({r, " ready timeout"}, 0, 1); break; end
    end
  endtask

  task automatic run_req(input string r, input logic [1:0] op, input logic [7:0] a,
                         input logic [15:0] d, output logic [15:0] q);
    logic [3:0] t;
    t = tag_ctr; tag_ctr++;
    @(posedge clk); #1;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_tag = t;
    wait_ready(r);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk({r, " rsp_valid"}, 32'(rsp_valid), 1);
    chk({r, " tag"}, 32'(rsp_tag), 32'(t));
    chk({r, " kind"}, 32'(rsp_is_load), 32'(op == 2'd0));
    q = rsp_data;
  endtask

  task automatic ld(input string r, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] q;
    run_req(r, 2'd0, a, '0, q);
    chk({r, " load value"}, 32'(q), 32'(exp));
  endtask

  task automatic op_ack(input string r, input logic [1:0] op, input logic [7:0] a,
                        input logic [15:0] d);
    logic [15:0] q;
    run_req(r, op, a, d, q);
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
    chk("R1 mo_valid after reset", 32'(mo_valid), 0);
    chk("R1 mi_ready", 32'(mi_ready), 1);
    ld("R1 R4 first load misses", 8'h10, bmem[8'h10]);
    chk("R1 R4 one CacheReq", 32'(n_creq), 1);
  endtask

  task automatic t_hit_store();
    ld("R2 load hit", 8'h10, bmem[8'h10]);
    chk("R2 no message on hit", 32'(n_creq), 1);
    op_ack("R3 store hit", 2'd1, 8'h10, 16'hBEEF);
    ld("R3 store visible", 8'h10, 16'hBEEF);
    chk("R3 no message", 32'(n_creq), 1);
    op_ack("R4 store miss", 2'd1, 8'h20, 16'hAAAA);
    chk("R4 store miss fetch", 32'(n_creq), 2);
    ld("R4 store miss value", 8'h20, 16'hAAAA);
  endtask

  task automatic t_recon_dirty();
    op_ack("R7 reconcile dirty", 2'd3, 8'h10, '0);
    op_ack("R7 reconcile invalid", 2'd3, 8'h55, '0);
    ld("R7 dirty data kept", 8'h10, 16'hBEEF);
    chk("R7 no CacheReq", 32'(n_creq), 2);
    chk("R7 no Wb", 32'(n_wb), 0);
  endtask

  task automatic t_commit();
    op_ack("R5 commit invalid", 2'd2, 8'h77, '0);
    chk("R5 no Wb", 32'(n_wb), 0);
    @(posedge clk); #1 mo_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'd2; req_addr = 8'h10; req_tag = tag_ctr;
    repeat (3) @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 R9 commit stalls", 32'(req_ready), 0);
      chk("R6 no early Ack", 32'(rsp_valid), 0);
      chk("R6 R12 Wb held", {14'(0), mo_kind, mo_addr, 8'(mo_valid)}, {14'(0), 2'd2, 8'h10, 8'd1});
      chk("R6 R12 Wb data", 32'(mo_data), 32'hBEEF);
    end
    @(posedge clk); #1 mo_ready = 1'b1;
    wait_ready("R6 commit completes");
    @(posedge clk); #1 req_valid = 1'b0; tag_ctr++;
    @(negedge clk);
    chk("R6 Ack after WbAck", 32'(rsp_valid && !rsp_is_load), 1);
    chk("R6 one Wb", 32'(n_wb), 1);
    chk("R6 memory updated", 32'(bmem[8'h10]), 32'hBEEF);
    op_ack("R5 commit clean", 2'd2, 8'h10, '0);
    chk("R5 commit clean no Wb", 32'(n_wb), 1);
  endtask

  task automatic t_recon_clean();
    bmem[8'h10] = 16'h1234;
    ld("R8 stale clean copy", 8'h10, 16'hBEEF);
    op_ack("R8 reconcile clean", 2'd3, 8'h10, '0);
    chk("R8 purge is silent", 32'(n_creq), 2);
    ld("R8 refetch", 8'h10, 16'h1234);
    chk("R8 CacheReq after purge", 32'(n_creq), 3);
  endtask

  task automatic t_fetch_stall();
    @(posedge clk); #1 mo_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'd0; req_addr = 8'h30; req_tag = tag_ctr;
    repeat (3) @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 fetch stall", 32'(req_ready), 0);
      chk("R4 R12 CacheReq held", {14'(0), mo_kind, mo_addr, 8'(mo_valid)}, {14'(0), 2'd0, 8'h30, 8'd1});
    end
    @(posedge clk); #1 mo_ready = 1'b1;
    wait_ready("R4 fetch completes");
    @(posedge clk); #1 req_valid = 1'b0; tag_ctr++;
    @(negedge clk);
    chk("R4 fetched value", 32'(rsp_data), 32'(bmem[8'h30]));
  endtask

  task automatic t_rsp_hold();
    logic [15:0] q;
    @(posedge clk); #1 rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'd0; req_addr = 8'h30; req_tag = 4'hA;
    wait_ready("R13 first accept");
    @(posedge clk); #1 req_tag = 4'hB;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R13 rsp held", {11'(0), rsp_valid, rsp_tag, rsp_data}, {11'(0), 1'b1, 4'hA, bmem[8'h30]});
      chk("R13 no second accept", 32'(req_ready), 0);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    wait_ready("R13 second accept");
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    q = rsp_data;
    chk("R13 second response", {12'(0), rsp_tag, q}, {12'(0), 4'hB, bmem[8'h30]});
  endtask

  task automatic t_evict();
    ld("R10 fill last cell", 8'h40, bmem[8'h40]);
    ld("R10 drop clean", 8'h50, bmem[8'h50]);
    chk("R10 silent drop", 32'(n_wb), 1);
    chk("R10 fetch count", 32'(n_creq), 6);
    ld("R10 dirty kept", 8'h20, 16'hAAAA);
    chk("R10 dirty hit no fetch", 32'(n_creq), 6);
    ld("R10 dropped line refetched", 8'h10, 16'h1234);
    chk("R10 refetch count", 32'(n_creq), 7);
  endtask

  task automatic t_all_dirty();
    op_ack("R11 store 60", 2'd1, 8'h60, 16'h6060);
    op_ack("R11 store 61", 2'd1, 8'h61, 16'h6161);
    op_ack("R11 store 62", 2'd1, 8'h62, 16'h6262);
    chk("R11 no Wb yet", 32'(n_wb), 1);
    op_ack("R11 store with all dirty", 2'd1, 8'h63, 16'h6363);
    chk("R11 one victim Wb", 32'(n_wb), 2);
    chk("R11 victim data in memory", 32'(bmem[8'h60]), 32'h6060);
    chk("R11 R12 Wb before CacheReq", {30'(0), prev_kind}, 2);
    chk("R11 R12 CacheReq last", {30'(0), last_kind}, 0);
    ld("R11 victim reread", 8'h60, 16'h6060);
    chk("R11 second victim Wb", 32'(n_wb), 3);
    chk("R11 second victim data", 32'(bmem[8'h63]), 32'h6363);
    ld("R11 other dirty untouched", 8'h20, 16'hAAAA);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    chk("watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 16'(i * 37 + 5);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit_store();
    t_recon_dirty();
    t_commit();
    t_recon_clean();
    t_fetch_stall();
    t_rsp_hold();
    t_evict();
    t_all_dirty();
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule